// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block serves reads on a memory-mapped window by running a complete serial flash read sequence for each bus access. It keeps one packed setup word per chip select. Each word sets the read opcode, how many address bytes follow it, how many dummy bytes come next, and how many data lines carry the returned bytes. A bus read lowers the chosen chip select and shifts out the opcode and the address on one line. The engine then clocks the dummy bytes with its outputs released, gathers 1 to 4 data bytes on one, two or four lines, and returns them as a single response word.

The serial pins are shared with a separate register-driven command engine. A one-bit switch register decides which engine owns the pins. An access that has already started keeps the pins until it finishes. A read that the engine cannot serve is answered at once with an error and zero data. Reads are refused when the switch is off, when the length is outside 1..4, or when the access runs past the end of the window.

Top module: `flash_mm_read_top`

## Requirements
- R1: After reset every setup word and the switch bit are 0, `rd_ready` is 1, `rsp_valid` is 0, and the serial outputs repeat the `cmd_*` inputs.
- R2: A write with `cfg_addr` 0..3 loads the setup word of that chip select. The opcode in bits 7:0 is sent first, MSB first, on `io_out[0]` (with `io_oe` = 0001) while only `cs_n[rd_cs]` is low.
- R3: Setup bits 9:8 hold the address byte count minus one. The low 8×(field+1) bits of `rd_addr` follow the opcode, MSB first, on `io_out[0]`.
- R4: Setup bits 11:10 give the dummy byte count. The engine clocks 8×field dummy cycles after the address with `io_oe` = 0000.
- R5: Setup bits 13:12 pick the data lines: 1 gives two lines on `io_in[1:0]`, 3 gives four lines on `io_in[3:0]`, and 0 or 2 gives one line on `io_in[1]`. Within each byte, bits arrive MSB first, and the higher-numbered line carries the more significant bit.
- R6: The first received byte lands in `rsp_data[7:0]` and later bytes fill upward. Bytes beyond `rd_len` read as 0.
- R7: `sclk` runs at half the clock rate, low then high for each bit, and is idle low. For an access with N serial bits, accepted at clock edge E, `rsp_valid` is high for exactly one cycle, the one starting at edge E+2N. `rd_ready` is low from E until that pulse ends.
- R8: With switch bit 0 at 1 (`cfg_addr` 4), the engine drives the pins. With it at 0, the pins repeat the `cmd_*` inputs, except that an access already in progress keeps the pins until it completes.
- R9: A read accepted while the switch is 0 answers in the next cycle with `rsp_err` = 1 and `rsp_data` = 0, and no chip select is lowered.
- R10: A read with `rd_addr` + `rd_len` above WINDOW_BYTES, or with `rd_len` of 0 or more than 4, is answered like R9. An access that ends exactly at the window end is served.
- R11: At most one `cs_n` bit is low at any time. The selected chip select is high again in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setup/switch register write strobe |
| cfg_addr | input | 3 | 0..NUM_CS-1 setup word, NUM_CS switch |
| cfg_wdata | input | 14 | Write data |
| rd_valid | input | 1 | Bus read request |
| rd_ready | output | 1 | Engine idle, request accepted this edge |
| rd_addr | input | 24 | Byte offset within window |
| rd_len | input | 3 | Byte count, 1..4 |
| rd_cs | input | 2 | Chip select of the read |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Read data, first byte lowest |
| rsp_err | output | 1 | Request refused |
| cmd_sclk | input | 1 | Command engine serial clock |
| cmd_cs_n | input | 4 | Command engine chip selects |
| cmd_io_out | input | 4 | Command engine data out |
| cmd_io_oe | input | 4 | Command engine output enables |
| sclk | output | 1 | Serial clock pin |
| cs_n | output | 4 | Chip select pins, active low |
| io_out | output | 4 | Data pin outputs |
| io_oe | output | 4 | Data pin output enables |
| io_in | input | 4 | Data pin inputs |

## Verification
A served read with N serial bits has its response due 2N+1 falling clock edges after the falling edge at which the request is raised. A refused read answers at the first falling edge after acceptance. A register write takes effect at the rising edge that follows it. The bench counts falling edges from acceptance and checks the busy, chip select and `sclk` phase at every edge before the response. It then requires the response to appear exactly at the computed edge and checks it there. The bench's flash model samples `io_out` on rising `sclk` edges and changes `io_in` on falling ones, so each data bit is stable before the engine samples it.

// File: rtl/flash_mm_pkg.sv
package flash_mm_pkg;

  localparam int SETUP_W = 14;

  typedef struct packed {
    logic [1:0] width_code;
    logic [1:0] dummy_bytes;
    logic [1:0] addr_bytes_m1;
    logic [7:0] opcode;
  } setup_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_DONE
  } seq_state_e;

  function automatic logic [2:0] lines_of(input logic [1:0] code);
    case (code)
      2'd1:    return 3'd2;
      2'd3:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [7:0] addr_slots(input logic [1:0] m1);
    return ({6'b0, m1} + 8'd1) << 3;
  endfunction

  function automatic logic [7:0] dummy_slots(input logic [1:0] nbytes);
    return {3'b0, nbytes, 3'b000};
  endfunction

  function automatic logic [7:0] data_slots(input logic [2:0] len_bytes,
                                            input logic [2:0] lines);
    logic [7:0] bits;
    bits = {2'b0, len_bytes, 3'b000};
    case (lines)
      3'd4:    return bits >> 2;
      3'd2:    return bits >> 1;
      default: return bits;
    endcase
  endfunction

endpackage

// File: rtl/flash_mm_cfg.sv
module flash_mm_cfg
  import flash_mm_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CA_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CA_W-1:0]          cfg_addr,
  input  logic [SETUP_W-1:0]       cfg_wdata,
  output setup_t [NUM_CS-1:0]      setups,
  output logic                     sw_mm
);

  localparam logic [CA_W-1:0] SW_ADDR = CA_W'(NUM_CS);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_setup
    setup_t word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '0;
      else if (cfg_we && cfg_addr == CA_W'(g))
        word_q <= setup_t'(cfg_wdata);
    end
    assign setups[g] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sw_mm <= 1'b0;
    else if (cfg_we && cfg_addr == SW_ADDR)
      sw_mm <= cfg_wdata[0];
  end

endmodule

// File: rtl/flash_mm_seq.sv
module flash_mm_seq
  import flash_mm_pkg::*;
#(
  parameter int NUM_CS       = 4,
  parameter int ADDR_W       = 24,
  parameter int WINDOW_BYTES = 1 << 20,
  parameter int CS_W         = 2,
  parameter int LEN_W        = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  setup_t [NUM_CS-1:0]   setups,
  input  logic                  sw_mm,
  input  logic                  rd_valid,
  output logic                  rd_ready,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [LEN_W-1:0]      rd_len,
  input  logic [CS_W-1:0]       rd_cs,
  output logic                  rsp_valid,
  output logic [31:0]           rsp_data,
  output logic                  rsp_err,
  input  logic [3:0]            io_in,
  output logic                  eng_sclk,
  output logic [NUM_CS-1:0]     eng_cs_n,
  output logic [3:0]            eng_io_out,
  output logic [3:0]            eng_io_oe,
  output logic                  eng_active,
  output logic                  ev_accept,
  output logic                  ev_reject,
  output logic                  ev_sample
);

  localparam int MAX_BYTES = 4;
  localparam logic [ADDR_W:0] WIN_L = (ADDR_W+1)'(WINDOW_BYTES);

  seq_state_e  state;
  logic        ph;
  logic [7:0]  slots_left;
  logic [39:0] tx_sr;
  setup_t      cur;
  logic [2:0]  len_q;
  logic [CS_W-1:0] cs_q;
  logic [7:0]  acc;
  logic [3:0]  acc_bits;
  logic [1:0]  byte_idx;
  logic [31:0] rx;
  logic        err_q;

  // request decode
  setup_t      rd_setup;
  logic [31:0] addr32;
  logic [31:0] addr_left;
  logic [ADDR_W:0] end_addr;
  logic        req_bad;

  assign rd_setup = setups[rd_cs];
  assign addr32   = 32'(rd_addr);
  assign end_addr = {1'b0, rd_addr} + (ADDR_W+1)'(rd_len);

  always_comb begin
    case (rd_setup.addr_bytes_m1)
      2'd0:    addr_left = {addr32[7:0], 24'b0};
      2'd1:    addr_left = {addr32[15:0], 16'b0};
      2'd2:    addr_left = {addr32[23:0], 8'b0};
      default: addr_left = addr32;
    endcase
  end

  assign ev_accept = rd_valid && (state == S_IDLE);
  assign req_bad   = !sw_mm || (rd_len == '0) || (rd_len > LEN_W'(MAX_BYTES)) ||
                     (end_addr > WIN_L);
  assign ev_reject = ev_accept && req_bad;

  // data capture
  logic [2:0]  lines;
  logic [3:0]  in_bits;
  logic [7:0]  acc_next;
  logic [3:0]  acc_bits_next;
  logic        slot_end;

  assign lines = lines_of(cur.width_code);

  always_comb begin
    case (lines)
      3'd4:    in_bits = io_in;
      3'd2:    in_bits = {2'b00, io_in[1:0]};
      default: in_bits = {3'b000, io_in[1]};
    endcase
  end

  assign acc_next      = (acc << lines) | {4'b0, in_bits};
  assign acc_bits_next = acc_bits + {1'b0, lines};

  assign eng_active = (state == S_CMD) || (state == S_ADDR) ||
                      (state == S_DUMMY) || (state == S_DATA);
  assign slot_end   = eng_active && ph;
  assign ev_sample  = slot_end && (state == S_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      ph         <= 1'b0;
      slots_left <= '0;
      tx_sr      <= '0;
      cur        <= '0;
      len_q      <= '0;
      cs_q       <= '0;
      acc        <= '0;
      acc_bits   <= '0;
      byte_idx   <= '0;
      rx         <= '0;
      err_q      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ev_accept) begin
            rx <= '0;
            if (req_bad) begin
              err_q <= 1'b1;
              state <= S_DONE;
            end else begin
              err_q      <= 1'b0;
              cur        <= rd_setup;
              cs_q       <= rd_cs;
              len_q      <= 3'(rd_len);
              tx_sr      <= {rd_setup.opcode, addr_left};
              slots_left <= 8'd8;
              ph         <= 1'b0;
              acc        <= '0;
              acc_bits   <= '0;
              byte_idx   <= '0;
              state      <= S_CMD;
            end
          end
        end
        S_CMD, S_ADDR, S_DUMMY, S_DATA: begin
          ph <= ~ph;
          if (ph) begin
            if (state == S_CMD || state == S_ADDR)
              tx_sr <= tx_sr << 1;
            if (state == S_DATA) begin
              acc <= acc_next;
              if (acc_bits_next == 4'd8) begin
                rx[{byte_idx, 3'b000} +: 8] <= acc_next;
                byte_idx <= byte_idx + 2'd1;
                acc_bits <= '0;
              end else begin
                acc_bits <= acc_bits_next;
              end
            end
            if (slots_left == 8'd1) begin
              case (state)
                S_CMD: begin
                  state      <= S_ADDR;
                  slots_left <= addr_slots(cur.addr_bytes_m1);
                end
                S_ADDR: begin
                  if (cur.dummy_bytes != 2'd0) begin
                    state      <= S_DUMMY;
                    slots_left <= dummy_slots(cur.dummy_bytes);
                  end else begin
                    state      <= S_DATA;
                    slots_left <= data_slots(len_q, lines);
                  end
                end
                S_DUMMY: begin
                  state      <= S_DATA;
                  slots_left <= data_slots(len_q, lines);
                end
                default: state <= S_DONE;
              endcase
            end else begin
              slots_left <= slots_left - 8'd1;
            end
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // pin side of the engine
  logic drive_cmd;
  assign drive_cmd  = (state == S_CMD) || (state == S_ADDR);
  assign eng_sclk   = eng_active && ph;
  assign eng_io_out = {3'b000, drive_cmd & tx_sr[39]};
  assign eng_io_oe  = drive_cmd ? 4'b0001 : 4'b0000;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign eng_cs_n[g] = !(eng_active && (cs_q == CS_W'(g)));
  end

  assign rd_ready  = (state == S_IDLE);
  assign rsp_valid = (state == S_DONE);
  assign rsp_data  = rx;
  assign rsp_err   = err_q;

endmodule

// File: rtl/flash_mm_pinmux.sv
module flash_mm_pinmux #(
  parameter int NUM_CS = 4
) (
  input  logic              sel_eng,
  input  logic              eng_sclk,
  input  logic [NUM_CS-1:0] eng_cs_n,
  input  logic [3:0]        eng_io_out,
  input  logic [3:0]        eng_io_oe,
  input  logic              cmd_sclk,
  input  logic [NUM_CS-1:0] cmd_cs_n,
  input  logic [3:0]        cmd_io_out,
  input  logic [3:0]        cmd_io_oe,
  output logic              pin_sclk,
  output logic [NUM_CS-1:0] pin_cs_n,
  output logic [3:0]        pin_io_out,
  output logic [3:0]        pin_io_oe
);

  assign pin_sclk   = sel_eng ? eng_sclk   : cmd_sclk;
  assign pin_cs_n   = sel_eng ? eng_cs_n   : cmd_cs_n;
  assign pin_io_out = sel_eng ? eng_io_out : cmd_io_out;
  assign pin_io_oe  = sel_eng ? eng_io_oe  : cmd_io_oe;

endmodule

// File: rtl/flash_mm_read_top.sv
module flash_mm_read_top
  import flash_mm_pkg::*;
#(
  parameter int NUM_CS       = 4,
  parameter int ADDR_W       = 24,
  parameter int WINDOW_BYTES = 1 << 20,
  parameter int LEN_W        = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [$clog2(NUM_CS+1)-1:0] cfg_addr,
  input  logic [SETUP_W-1:0]          cfg_wdata,
  input  logic                        rd_valid,
  output logic                        rd_ready,
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic [LEN_W-1:0]            rd_len,
  input  logic [$clog2(NUM_CS)-1:0]   rd_cs,
  output logic                        rsp_valid,
  output logic [31:0]                 rsp_data,
  output logic                        rsp_err,
  input  logic                        cmd_sclk,
  input  logic [NUM_CS-1:0]           cmd_cs_n,
  input  logic [3:0]                  cmd_io_out,
  input  logic [3:0]                  cmd_io_oe,
  output logic                        sclk,
  output logic [NUM_CS-1:0]           cs_n,
  output logic [3:0]                  io_out,
  output logic [3:0]                  io_oe,
  input  logic [3:0]                  io_in
);

  localparam int CS_W = $clog2(NUM_CS);
  localparam int CA_W = $clog2(NUM_CS + 1);

  setup_t [NUM_CS-1:0] setups;
  logic                sw_mm;
  logic                eng_sclk;
  logic [NUM_CS-1:0]   eng_cs_n;
  logic [3:0]          eng_io_out;
  logic [3:0]          eng_io_oe;
  logic                eng_active;
  logic                ev_accept;
  logic                ev_reject;
  logic                ev_sample;
  logic                sel_eng;

  flash_mm_cfg #(.NUM_CS(NUM_CS), .CA_W(CA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .setups(setups), .sw_mm(sw_mm)
  );

  flash_mm_seq #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW_BYTES),
    .CS_W(CS_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .setups(setups), .sw_mm(sw_mm),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_len(rd_len), .rd_cs(rd_cs), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .io_in(io_in),
    .eng_sclk(eng_sclk), .eng_cs_n(eng_cs_n), .eng_io_out(eng_io_out),
    .eng_io_oe(eng_io_oe), .eng_active(eng_active), .ev_accept(ev_accept),
    .ev_reject(ev_reject), .ev_sample(ev_sample)
  );

  // an access in flight holds the pins even if the switch drops
  assign sel_eng = sw_mm | eng_active;

  flash_mm_pinmux #(.NUM_CS(NUM_CS)) u_mux (
    .sel_eng(sel_eng), .eng_sclk(eng_sclk), .eng_cs_n(eng_cs_n),
    .eng_io_out(eng_io_out), .eng_io_oe(eng_io_oe), .cmd_sclk(cmd_sclk),
    .cmd_cs_n(cmd_cs_n), .cmd_io_out(cmd_io_out), .cmd_io_oe(cmd_io_oe),
    .pin_sclk(sclk), .pin_cs_n(cs_n), .pin_io_out(io_out), .pin_io_oe(io_oe)
  );

endmodule

// File: rtl/flash_mm_read_chk.sv
module flash_mm_read_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_data,
  input logic              sw_mm,
  input logic              eng_active,
  input logic              eng_sclk,
  input logic              ev_sample,
  input logic [NUM_CS-1:0] eng_cs_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sclk,
  input logic [3:0]        io_oe,
  input logic              cmd_sclk,
  input logic [NUM_CS-1:0] cmd_cs_n,
  input logic [3:0]        cmd_io_oe
);

  a_r11_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r11_cs_released_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (eng_cs_n == '1));

  a_r7_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active |-> !rd_ready);

  a_r7_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_active |-> !eng_sclk);

  a_r5_sample_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sample |-> eng_sclk);

  a_r9_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));

  a_r9_switch_off_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !sw_mm) |=> (rsp_valid && rsp_err));

  a_r8_cmd_owns_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_mm && !eng_active) |->
      (sclk == cmd_sclk && cs_n == cmd_cs_n && io_oe == cmd_io_oe));

  a_r2_cs_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_active && $past(eng_active)) |-> $stable(eng_cs_n));

endmodule

bind flash_mm_read_top flash_mm_read_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
  .sw_mm(sw_mm), .eng_active(eng_active), .eng_sclk(eng_sclk),
  .ev_sample(ev_sample), .eng_cs_n(eng_cs_n), .cs_n(cs_n), .sclk(sclk),
  .io_oe(io_oe), .cmd_sclk(cmd_sclk), .cmd_cs_n(cmd_cs_n),
  .cmd_io_oe(cmd_io_oe)
);

// File: tb/sim_flash_mm_read_top.sv
module sim_flash_mm_read_top;

  localparam int WIN = 1 << 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [13:0] cfg_wdata;
  logic        rd_valid;
  logic        rd_ready;
  logic [23:0] rd_addr;
  logic [2:0]  rd_len;
  logic [1:0]  rd_cs;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_err;
  logic        cmd_sclk;
  logic [3:0]  cmd_cs_n, cmd_io_out, cmd_io_oe;
  logic        sclk;
  logic [3:0]  cs_n, io_out, io_oe, io_in;

  always #4 clk = ~clk;

  flash_mm_read_top u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_len(rd_len), .rd_cs(rd_cs),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .cmd_sclk(cmd_sclk), .cmd_cs_n(cmd_cs_n), .cmd_io_out(cmd_io_out),
    .cmd_io_oe(cmd_io_oe), .sclk(sclk), .cs_n(cs_n), .io_out(io_out),
    .io_oe(io_oe), .io_in(io_in)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      chk(1'b0, "R7", "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // behavioural flash model
  bit          model_on = 1'b0;
  int          rises, m_hdr, m_dum, m_w, m_cs, m_addr, oe_bad;
  logic [7:0]  op_cap;
  logic [31:0] addr_cap;

  function automatic logic [7:0] fbyte(input int cs, input int a);
    return 8'(a * 7 + cs * 61 + 3);
  endfunction

  always @(posedge sclk) if (model_on) begin
    if (rises < 8) op_cap = {op_cap[6:0], io_out[0]};
    else if (rises < m_hdr) addr_cap = {addr_cap[30:0], io_out[0]};
    else if (rises < m_hdr + m_dum) begin
      if (io_oe != 4'b0000) oe_bad++;
    end
    rises++;
  end

  always @(negedge sclk) if (model_on) begin
    int j, bi, b, v;
    j = rises - m_hdr - m_dum;
    if (j >= 0) begin
      bi = j * m_w;
      b  = int'(fbyte(m_cs, m_addr + bi / 8));
      v  = (b >> (8 - (bi % 8) - m_w)) & ((1 << m_w) - 1);
      io_in = (m_w == 1) ? 4'(v << 1) : 4'(v);
    end
  end

  // bench copy of the programmed setup words
  int s_op[4], s_na[4], s_nd[4], s_wc[4];

  task automatic cfg_write(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 14'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_setup(input int cs, input int op, input int na,
                           input int nd, input int wc);
    s_op[cs] = op; s_na[cs] = na; s_nd[cs] = nd; s_wc[cs] = wc;
    cfg_write(cs, op | ((na - 1) << 8) | (nd << 10) | (wc << 12));
  endtask

  task automatic do_read(input int cs, input int addr, input int len,
                         input bit exp_err, input int sw_off_at, input string rq);
    int w, n, last, cnt, bad;
    logic [31:0] exp_d;
    w = (s_wc[cs] == 3) ? 4 : (s_wc[cs] == 1) ? 2 : 1;
    m_hdr = 8 + 8 * s_na[cs];
    m_dum = 8 * s_nd[cs];
    m_w = w; m_cs = cs; m_addr = addr;
    n = m_hdr + m_dum + (8 * len) / w;
    last = exp_err ? 1 : 2 * n + 1;
    exp_d = '0;
    if (!exp_err)
      for (int k = 0; k < len; k++) exp_d[8*k +: 8] = fbyte(cs, addr + k);
    rises = 0; op_cap = '0; addr_cap = '0; oe_bad = 0; model_on = 1'b1;
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = 24'(addr); rd_len = 3'(len); rd_cs = 2'(cs);
    @(negedge clk);
    rd_valid = 1'b0;
    cnt = 1; bad = 0;
    while (!rsp_valid && cnt <= last + 3) begin
      if (rd_ready) bad++;
      if (!exp_err && (cs_n[cs] !== 1'b0 || sclk !== (cnt % 2 == 0))) bad++;
      if (cnt == sw_off_at) begin
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = '0;
      end else if (cnt == sw_off_at + 1) cfg_we = 1'b0;
      @(negedge clk);
      cnt++;
    end
    chk(cnt == last, {rq, " R7"}, "response cycle", cnt, last);
    chk(bad == 0, {rq, " R7 R11"}, "per-cycle busy/cs/sclk mismatches", bad, 0);
    chk(rsp_err == exp_err, rq, "rsp_err", rsp_err, exp_err);
    chk(rsp_data == exp_d, {rq, " R6"}, "rsp_data", rsp_data, exp_d);
    if (!exp_err) begin
      chk(op_cap == 8'(s_op[cs]), "R2", "opcode", op_cap, s_op[cs]);
      chk(addr_cap == (32'(addr) & (32'hFFFF_FFFF >> (32 - 8 * s_na[cs]))),
          "R3", "address", addr_cap, addr);
      chk(oe_bad == 0, "R4", "dummy outputs driven", oe_bad, 0);
      if (sw_off_at < 0)
        chk(cs_n == 4'hF, "R11", "cs released at response", cs_n, 4'hF);
    end
    model_on = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rd_valid = 1'b0; rd_addr = '0; rd_len = '0; rd_cs = '0; io_in = '0;
    cmd_sclk = 1'b1; cmd_cs_n = 4'b1110; cmd_io_out = 4'b0101; cmd_io_oe = 4'b0011;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, pins follow the command engine
    chk(rd_ready == 1'b1, "R1", "rd_ready", rd_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    chk(cs_n == 4'b1110 && sclk == 1'b1, "R1", "cs_n/sclk from cmd", cs_n, 4'b1110);
    chk(io_oe == 4'b0011 && io_out == 4'b0101, "R1", "io from cmd", io_oe, 4'b0011);
    cmd_sclk = 1'b0; cmd_cs_n = 4'hF; cmd_io_oe = '0; cmd_io_out = '0;

    // R9 switch off: refused
    set_setup(0, 8'h03, 3, 0, 0);
    do_read(0, 24'h000100, 4, 1'b1, -1, "R9");

    cfg_write(4, 1);
    // single line, three address bytes
    do_read(0, 24'h012345, 4, 1'b0, -1, "R2 R3 R5");
    // dual line, two address bytes, one dummy byte
    set_setup(1, 8'h3B, 2, 1, 1);
    do_read(1, 24'h0ABCDE, 2, 1'b0, -1, "R4 R5");
    // quad line, four address bytes, two dummy bytes
    set_setup(2, 8'h6B, 4, 2, 3);
    do_read(2, 24'h0F00A5, 3, 1'b0, -1, "R4 R5");
    // width code 2 falls back to one line, one address byte, three dummy bytes
    set_setup(3, 8'hC7, 1, 3, 2);
    do_read(3, 24'h000077, 1, 1'b0, -1, "R5");

    // R10 window edge and bad lengths
    do_read(0, WIN - 2, 2, 1'b0, -1, "R10");
    do_read(0, WIN - 2, 3, 1'b1, -1, "R10");
    do_read(0, 24'h000010, 0, 1'b1, -1, "R10");
    do_read(0, 24'h000010, 5, 1'b1, -1, "R10");

    // R8 switch dropped mid-access: access completes, then pins return
    cmd_cs_n = 4'b0111;
    do_read(1, 24'h000321, 4, 1'b0, 5, "R8");
    chk(cs_n == 4'b0111 && sclk == 1'b0, "R8", "pins back to cmd", cs_n, 4'b0111);
    do_read(1, 24'h000321, 4, 1'b1, -1, "R8 R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule